// File: doc/BRIEF.md
# Challenge-Response Authentication Engine

This block is the device-side half of a byte-wide challenge-response handshake between a host and a network adapter. The host starts a round by writing the start key to a control register. The engine then latches a fresh 32-bit challenge from a free-running LFSR and raises a request cause bit. The host reads the challenge one byte at a time, most significant byte first. It mixes the challenge with the adapter's revision byte and 16-bit device identifier, using 8-bit additions, multiplications and XORs, and writes the 32-bit answer back one byte at a time.

When the last answer byte arrives, the engine compares the answer with the value it computed itself. It records pass or fail in a result register and raises a completion cause bit. The cause bits are cleared by writing 1 to them, and a level interrupt stays asserted while any cause bit is set. All accesses use a plain single-cycle register port. There is no back-pressure: every access completes in the cycle it is presented, and read data is combinational from the address.

Top module: `auth_engine`

## Requirements
- R1: After reset, the cause register (0x03) and the result register (0x0B) read 0x00 and `irq` is low.
- R2: A write of 0x4E to register 0x05 latches a new challenge from the free-running LFSR and sets cause bit 4 (value 0x10). A write of any other value to 0x05 changes neither the challenge nor the cause register.
- R3: Reads of register 0x08 return the challenge bytes in the order bits 31:24, 23:16, 15:8, 7:0, then wrap to bits 31:24. The challenge is never zero, and it stays unchanged until the next accepted start write.
- R4: The answer is written to register 0x09 as four bytes, the most significant first. The fourth write of a round triggers the comparison.
- R5: With challenge bytes i0 (bits 31:24) to i3 (bits 7:0), revision r and device ID bytes e0 (high) and e1 (low), all arithmetic modulo 256, the expected answer is {c0,c1,c2,c3}. The terms are c0=(i0+i1*0xC1+0x18+r)^(i3*i2+0x90), c1=(i1+i2+0x90)^(c0+i0-0xC1), c2=(i2+0xC8)^(c0+((e0+r*0x23)^0x19)) and c3=(i0+0xC1)^(i3+((e1+0xC8)^0x90)).
- R6: After a comparison, register 0x0B reads 0x01 on a match and 0x00 on a mismatch. The value holds until the next comparison.
- R7: A comparison sets cause bit 3 (value 0x08) and ends the round. Writing 1 to a cause bit at 0x03 clears that bit, and writing 0 leaves it unchanged.
- R8: Writes to 0x09 outside a round are ignored. A round starts with an accepted start write and ends with its comparison. Such writes change neither the result register nor the cause register.
- R9: `irq` is high exactly while at least one cause bit is set.
- R10: An accepted start write restarts both the challenge read position and the answer write position at the most significant byte, including in the middle of a round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (advances the challenge byte position) |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| rev_id | input | 8 | Revision byte used in the answer |
| dev_id | input | 16 | Device identifier used in the answer |
| irq | output | 1 | Level interrupt, high while any cause bit is set |

## Verification
The assertions check every cycle that the challenge register moves only on an accepted start write and that the LFSR never reaches zero. They also check that the result register moves only on a comparison, that a comparison sets the completion bit and ends the round, and that answer writes outside a round leave result and cause alone. Only the bench scenarios can show the arithmetic of the answer: they compare it against an independent model across several challenges and identity values. The same applies to the byte ordering and wrap of challenge reads, the per-bit clearing of causes, and the restart of both byte positions when a start write arrives mid-round.

// File: rtl/auth_pkg.sv
package auth_pkg;
  typedef logic [7:0] octet_t;

  // register offsets decoded by the host
  localparam octet_t REG_CAUSE  = 8'h03;
  localparam octet_t REG_START  = 8'h05;
  localparam octet_t REG_CHAL   = 8'h08;
  localparam octet_t REG_RSP    = 8'h09;
  localparam octet_t REG_RESULT = 8'h0B;

  // cause bit positions
  localparam int CAUSE_DONE_BIT = 3;
  localparam int CAUSE_REQ_BIT  = 4;

  // value that opens a round
  localparam octet_t START_KEY = 8'h4E;
endpackage

// File: rtl/auth_lfsr.sv
module auth_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = 32'h8020_0003,
  parameter logic [W-1:0] SEED = 32'h1D2C_3B4A
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  logic [W-1:0] nxt;

  // right-shifting Galois form; zero is unreachable from a non-zero seed
  always_comb begin
    nxt = {1'b0, state[W-1:1]};
    if (state[0]) nxt = nxt ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED;
    else        state <= nxt;
  end
endmodule

// File: rtl/auth_byte_seq.sv
module auth_byte_seq #(
  parameter  int N  = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          step,
  output logic [PW-1:0] idx,
  output logic          last
);
  assign last = (idx == PW'(N - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       idx <= '0;
    else if (restart) idx <= '0;
    else if (step)    idx <= last ? '0 : idx + 1'b1;
  end
endmodule

// File: rtl/auth_rsp_calc.sv
module auth_rsp_calc (
  input  logic [31:0] chal,
  input  logic [7:0]  rev,
  input  logic [15:0] dev,
  output logic [31:0] rsp
);
  logic [7:0] b0, b1, b2, b3, hi_id, lo_id;
  logic [7:0] mix_a, mix_b, id_mix, lo_mix;
  logic [7:0] r0, r1, r2, r3;

  assign b0    = chal[31:24];
  assign b1    = chal[23:16];
  assign b2    = chal[15:8];
  assign b3    = chal[7:0];
  assign hi_id = dev[15:8];
  assign lo_id = dev[7:0];

  always_comb begin
    mix_a  = b0 + b1 * 8'hC1 + 8'h18 + rev;
    mix_b  = b3 * b2 + 8'h90;
    r0     = mix_a ^ mix_b;
    r1     = (b1 + b2 + 8'h90) ^ (r0 + b0 - 8'hC1);
    id_mix = (hi_id + rev * 8'h23) ^ 8'h19;
    r2     = (b2 + 8'hC8) ^ (r0 + id_mix);
    lo_mix = (lo_id + 8'hC8) ^ 8'h90;
    r3     = (b0 + 8'hC1) ^ (b3 + lo_mix);
  end

  assign rsp = {r0, r1, r2, r3};
endmodule

// File: rtl/auth_engine.sv
module auth_engine
  import auth_pkg::*;
#(
  parameter int                      CHAL_BYTES = 4,
  localparam int                     CHAL_W     = CHAL_BYTES * 8,
  parameter logic [CHAL_W-1:0]       LFSR_TAPS  = 32'h8020_0003,
  parameter logic [CHAL_W-1:0]       LFSR_SEED  = 32'h1D2C_3B4A,
  localparam int                     PW         = (CHAL_BYTES > 1) ? $clog2(CHAL_BYTES) : 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  input  logic [7:0]  rev_id,
  input  logic [15:0] dev_id,
  output logic        irq
);
  logic [CHAL_W-1:0] lfsr_q, chal_q, expect_w, got_w;
  logic              start_hit, wr_rsp, check_evt, rd_chal, armed;
  logic              pass_q, cause_req_q, cause_done_q;
  logic [PW-1:0]     rptr, wptr;
  logic              rlast, wlast;
  octet_t            chal_b [CHAL_BYTES];
  octet_t            rsp_b  [CHAL_BYTES];

  // decode
  assign start_hit = wr_en && (addr == REG_START) && (wdata == START_KEY);
  assign wr_rsp    = wr_en && (addr == REG_RSP) && armed;
  assign check_evt = wr_rsp && wlast;
  assign rd_chal   = rd_en && (addr == REG_CHAL);

  auth_lfsr #(.W(CHAL_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(lfsr_q)
  );

  // challenge holds between accepted start writes
  always_ff @(posedge clk) begin
    if (!rst_n)         chal_q <= '0;
    else if (start_hit) chal_q <= lfsr_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         armed <= 1'b0;
    else if (start_hit) armed <= 1'b1;
    else if (check_evt) armed <= 1'b0;
  end

  auth_byte_seq #(.N(CHAL_BYTES)) u_rd_seq (
    .clk(clk), .rst_n(rst_n), .restart(start_hit), .step(rd_chal),
    .idx(rptr), .last(rlast)
  );

  auth_byte_seq #(.N(CHAL_BYTES)) u_wr_seq (
    .clk(clk), .rst_n(rst_n), .restart(start_hit), .step(wr_rsp),
    .idx(wptr), .last(wlast)
  );

  // byte views, most significant first
  for (genvar k = 0; k < CHAL_BYTES; k++) begin : g_bytes
    assign chal_b[k] = chal_q[CHAL_W-1-8*k -: 8];
    if (k == CHAL_BYTES - 1) begin : g_tail
      assign rsp_b[k] = wdata;
    end else begin : g_hold
      always_ff @(posedge clk) begin
        if (!rst_n)                              rsp_b[k] <= '0;
        else if (wr_rsp && (wptr == PW'(k)))     rsp_b[k] <= wdata;
      end
    end
    assign got_w[CHAL_W-1-8*k -: 8] = rsp_b[k];
  end

  auth_rsp_calc u_calc (
    .chal(chal_q), .rev(rev_id), .dev(dev_id), .rsp(expect_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         pass_q <= 1'b0;
    else if (check_evt) pass_q <= (got_w == expect_w);
  end

  // cause bits: set by events, cleared by writing 1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cause_req_q  <= 1'b0;
      cause_done_q <= 1'b0;
    end else begin
      if (start_hit)
        cause_req_q <= 1'b1;
      else if (wr_en && (addr == REG_CAUSE) && wdata[CAUSE_REQ_BIT])
        cause_req_q <= 1'b0;
      if (check_evt)
        cause_done_q <= 1'b1;
      else if (wr_en && (addr == REG_CAUSE) && wdata[CAUSE_DONE_BIT])
        cause_done_q <= 1'b0;
    end
  end

  assign irq = cause_req_q | cause_done_q;

  always_comb begin
    rdata = '0;
    case (addr)
      REG_CAUSE: begin
        rdata[CAUSE_REQ_BIT]  = cause_req_q;
        rdata[CAUSE_DONE_BIT] = cause_done_q;
      end
      REG_CHAL:   rdata = chal_b[rptr];
      REG_RESULT: rdata = {7'b0, pass_q};
      default:    rdata = '0;
    endcase
  end

  logic unused_rlast;
  assign unused_rlast = rlast;
endmodule

// File: rtl/auth_engine_chk.sv
module auth_engine_chk
  import auth_pkg::*;
#(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [7:0]    addr,
  input logic [7:0]    wdata,
  input logic          irq,
  input logic          start_hit,
  input logic          check_evt,
  input logic          armed,
  input logic          pass_q,
  input logic          cause_req_q,
  input logic          cause_done_q,
  input logic [CW-1:0] chal_q,
  input logic [CW-1:0] lfsr_q
);
  assert_chal_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !start_hit |=> $stable(chal_q));

  assert_lfsr_live_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

  assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_START && wdata == START_KEY) |=> (cause_req_q && armed));

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !check_evt |=> $stable(pass_q));

  assert_check_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    check_evt |=> (cause_done_q && !armed));

  assert_unarmed_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_RSP && !armed) |=> ($stable(pass_q) && $stable(cause_done_q)));

  assert_clear_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == REG_CAUSE && wdata[CAUSE_REQ_BIT] && wdata[CAUSE_DONE_BIT]) |=> !irq);
endmodule

bind auth_engine auth_engine_chk #(.CW(CHAL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .irq(irq),
  .start_hit(start_hit), .check_evt(check_evt), .armed(armed), .pass_q(pass_q),
  .cause_req_q(cause_req_q), .cause_done_q(cause_done_q),
  .chal_q(chal_q), .lfsr_q(lfsr_q)
);

// File: tb/test_auth_engine.sv
module test_auth_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0, wdata = '0;
  logic [7:0]  rdata;
  logic [7:0]  rev_id = 8'hF0;
  logic [15:0] dev_id = 16'hD107;
  logic        irq;

  int unsigned n_vec = 0, n_bad = 0;
  logic        chk_rd = 1'b0;
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  always #5 clk = ~clk;

  auth_engine i_auth_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rev_id(rev_id), .dev_id(dev_id), .irq(irq)
  );

  function automatic logic [31:0] model(input logic [31:0] ch, input logic [7:0] r,
                                        input logic [15:0] d);
    logic [7:0] i0, i1, i2, i3, c0, c1, c2, c3, t;
    i0 = ch[31:24]; i1 = ch[23:16]; i2 = ch[15:8]; i3 = ch[7:0];
    c0 = i0 + i1 * 8'hC1 + 8'h18 + r;
    t  = i3 * i2 + 8'h90;
    c0 = c0 ^ t;
    c1 = (i1 + i2 + 8'h90) ^ (c0 + i0 - 8'hC1);
    t  = (d[15:8] + r * 8'h23) ^ 8'h19;
    c2 = (i2 + 8'hC8) ^ (c0 + t);
    t  = (d[7:0] + 8'hC8) ^ 8'h90;
    c3 = (i0 + 8'hC1) ^ (i3 + t);
    return {c0, c1, c2, c3};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every checked read
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (chk_rd) begin
        n_vec++;
        if (exp_q.size() == 0) begin
          n_bad++;
          $display("FAIL scoreboard: unexpected read, actual %0h expected none", rdata);
        end else begin
          logic [7:0] e;
          string      tg;
          e  = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (rdata !== e) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tg, rdata, e);
          end
        end
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #3 v = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    addr = a; rd_en = 1'b1; chk_rd = 1'b1;
    @(posedge clk); #1;
    rd_en = 1'b0; chk_rd = 1'b0;
  endtask

  task automatic read_chal(output logic [31:0] ch);
    logic [7:0] b;
    for (int k = 0; k < 4; k++) begin
      bus_rd(8'h08, b);
      ch = {ch[23:0], b};
    end
  endtask

  task automatic write_rsp(input logic [31:0] r);
    for (int k = 3; k >= 0; k--) bus_wr(8'h09, r[8*k +: 8]);
  endtask

  task automatic check_irq(input string tag, input logic e);
    @(negedge clk); #2;
    check(tag, irq, e);
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] ch, ch2, prev;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_expect(8'h03, 8'h00, "R1 cause after reset");
    rd_expect(8'h0B, 8'h00, "R1 result after reset");
    check_irq("R1 irq after reset", 1'b0);

    // R2 wrong key ignored
    bus_wr(8'h05, 8'h12);
    rd_expect(8'h03, 8'h00, "R2 non-key start ignored");
    check_irq("R2 irq stays low", 1'b0);

    // R2 / R9 valid start
    bus_wr(8'h05, 8'h4E);
    rd_expect(8'h03, 8'h10, "R2 start sets request cause");
    check_irq("R9 irq with request cause", 1'b1);

    // R3 ordering, wrap and stability
    read_chal(ch);
    check("R3 challenge non-zero", {31'b0, ch != 0}, 32'd1);
    repeat (5) @(posedge clk);
    for (int k = 3; k >= 0; k--) rd_expect(8'h08, ch[8*k +: 8], "R3 challenge wrap and hold");
    bus_wr(8'h05, 8'h77);
    for (int k = 3; k >= 0; k--) rd_expect(8'h08, ch[8*k +: 8], "R2 non-key keeps challenge");

    // R4 R5 R6 R7 correct answer
    write_rsp(model(ch, rev_id, dev_id));
    rd_expect(8'h0B, 8'h01, "R6 match reads 0x01 (R5 R4)");
    rd_expect(8'h03, 8'h18, "R7 done cause set");
    bus_wr(8'h03, 8'h10);
    rd_expect(8'h03, 8'h08, "R7 clear request only");
    bus_wr(8'h03, 8'h00);
    rd_expect(8'h03, 8'h08, "R7 writing zero keeps bit");
    check_irq("R9 irq with done cause", 1'b1);
    bus_wr(8'h03, 8'h08);
    rd_expect(8'h03, 8'h00, "R7 clear done");
    check_irq("R9 irq low when clear", 1'b0);

    // R8 answer writes outside a round
    write_rsp(32'h0000_0000);
    rd_expect(8'h0B, 8'h01, "R8 result unchanged");
    rd_expect(8'h03, 8'h00, "R8 no cause");

    // R6 mismatch
    prev = ch;
    bus_wr(8'h05, 8'h4E);
    read_chal(ch);
    check("R2 new challenge differs", {31'b0, ch != prev}, 32'd1);
    write_rsp(model(ch, rev_id, dev_id) ^ 32'h0000_0001);
    rd_expect(8'h0B, 8'h00, "R6 mismatch reads 0x00");
    rd_expect(8'h03, 8'h18, "R7 done after mismatch");
    bus_wr(8'h03, 8'h18);

    // R5 other identity values
    rev_id = 8'h3A; dev_id = 16'h5C21;
    bus_wr(8'h05, 8'h4E);
    read_chal(ch);
    write_rsp(model(ch, rev_id, dev_id));
    rd_expect(8'h0B, 8'h01, "R5 other identity match");
    bus_wr(8'h03, 8'h18);

    // R10 restart mid-round
    bus_wr(8'h05, 8'h4E);
    read_chal(ch);
    bus_wr(8'h09, 8'hAA);
    bus_wr(8'h09, 8'h55);
    bus_wr(8'h05, 8'h4E);
    read_chal(ch2);
    bus_wr(8'h05, 8'h4E);
    read_chal(ch);
    write_rsp(model(ch, rev_id, dev_id));
    rd_expect(8'h0B, 8'h01, "R10 positions restarted");
    bus_wr(8'h03, 8'h18);

    // R5 several challenges
    rev_id = 8'hF0; dev_id = 16'hD107;
    for (int n = 0; n < 6; n++) begin
      repeat (n * 3 + 1) @(posedge clk);
      bus_wr(8'h05, 8'h4E);
      read_chal(ch);
      write_rsp(model(ch, rev_id, dev_id));
      rd_expect(8'h0B, 8'h01, "R5 repeated challenge match");
      bus_wr(8'h03, 8'h18);
    end

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: actual %0d left expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule